// File: doc/BRIEF.md
# Key-Guarded Configuration Register

This block holds one configuration word that ordinary bus writes cannot change. It watches a plain write bus with an address, a data word and a write strobe. A new value takes effect only when three writes arrive in this order: an opening key word to the opening key address, the wanted value to the configuration address, and a closing key word to the closing key address. Each write is one cycle with the strobe high. The block keeps the value written in the middle step in a shadow register. The value reaches the live register, which drives the block's output, only when the closing write completes the sequence.

A wrong key, or a write to any of the three addresses out of turn, stops the sequence and discards the shadow. Writes to other addresses do not disturb a sequence that is in progress. A status output is high while a sequence is in progress. The read port is combinational on the address. It returns the live value at the configuration address and zero everywhere else, the key addresses included.

Top module: `keyedConfigReg`

## Requirements
- R1: After reset `cfgOut` is zero, `seqBusy` is low, and a read at the configuration address returns zero.
- R2: Three writes commit the value, and `cfgOut` shows it from the cycle after the closing write. The writes are: 0x0000009A to address 0x650, then a value to address 0x654, then 0x0000000C to address 0x658. Bits 15:0 of the middle write's data are the value that is committed.
- R3: `seqBusy` goes high in the cycle after a correct opening write. It stays high after the configuration write of a correct sequence and goes low after any write to 0x658.
- R4: A write to 0x650 whose full 32-bit data is not 0x0000009A leaves the block idle (`seqBusy` low). Later writes to 0x654 and 0x658 then commit nothing.
- R5: A write to 0x654 while idle has no effect on `cfgOut`, and a following correct closing write commits nothing.
- R6: A closing write with data other than 0x0000000C aborts the sequence and leaves `cfgOut` unchanged. A later correct closing write also commits nothing, because the shadow was discarded.
- R7: Writes out of order abort the sequence and leave `cfgOut` unchanged. This covers a closing write straight after the opening write, and a second configuration write after the first one.
- R8: A correct opening write made during a sequence restarts it from the first step and discards any value already held in the shadow.
- R9: Writes to addresses other than 0x650, 0x654 and 0x658 neither advance nor abort a sequence, and they do not change `cfgOut`.
- R10: Reads at 0x654 return `cfgOut` zero-extended to 32 bits. Reads at 0x650, 0x658 and any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one write per cycle while high |
| addr | input | 12 | Byte address offset for both writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cfgOut | output | 16 | Committed configuration value |
| seqBusy | output | 1 | High while an unlock sequence is in progress |

## Verification
The assertions assume that `addr` and `wdata` are settled whenever `wrEn` is high at a rising edge. They also assume that each cycle with `wrEn` high counts as exactly one write. The stimulus changes inputs only at falling edges and drops `wrEn` after one cycle, so repeated writes are always separate. The random phase draws its addresses mostly from the three guarded locations, with some unrelated ones mixed in. Key data is drawn so that both exact keys and near misses with stray upper bits occur, which keeps every branch of the sequence tracker busy.

// File: rtl/keycfg_pkg.sv
package keycfg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_LOADED = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadShadow;
    logic dropShadow;
    logic commit;
  } cfgStrobe_t;
endpackage

// File: rtl/keySeqCtrl.sv
module keySeqCtrl
  import keycfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OPEN_ADDR  = 12'h650,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 12'h654,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR = 12'h658,
  parameter logic [DATA_W-1:0] OPEN_KEY   = 32'h0000_009A,
  parameter logic [DATA_W-1:0] CLOSE_KEY  = 32'h0000_000C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfgStrobe_t        strobe,
  output logic              busy
);

  seqState_t state, nextState;

  logic hitOpen, hitCfg, hitClose;
  logic openOk, closeOk;

  assign hitOpen  = wrEn && (addr == OPEN_ADDR);
  assign hitCfg   = wrEn && (addr == CFG_ADDR);
  assign hitClose = wrEn && (addr == CLOSE_ADDR);
  assign openOk   = (wdata == OPEN_KEY);
  assign closeOk  = (wdata == CLOSE_KEY);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (hitOpen) begin
      strobe.dropShadow = 1'b1;
      nextState = openOk ? SEQ_ARMED : SEQ_IDLE;
    end else if (hitCfg) begin
      if (state == SEQ_ARMED) begin
        strobe.loadShadow = 1'b1;
        nextState = SEQ_LOADED;
      end else begin
        strobe.dropShadow = 1'b1;
        nextState = SEQ_IDLE;
      end
    end else if (hitClose) begin
      if (state == SEQ_LOADED && closeOk) begin
        strobe.commit = 1'b1;
      end else begin
        strobe.dropShadow = 1'b1;
      end
      nextState = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != SEQ_IDLE);

  // Sequence tracking checks
  assert_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hitOpen && openOk) |=> busy);
  assert_bad_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hitOpen && !openOk) |=> !busy);
  assert_stray_cfg_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hitCfg && !busy) |=> !busy);
  assert_close_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    hitClose |=> !busy);
  assert_unrelated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(hitOpen || hitCfg || hitClose) |=> $stable(busy));
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/keyCfgData.sv
module keyCfgData
  import keycfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h654
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_W-1:0]  wcfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [CFG_W-1:0]  liveCfg,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - CFG_W;

  logic [CFG_W-1:0] shadowCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shadowCfg <= '0;
    else if (strobe.loadShadow) shadowCfg <= wcfg;
    else if (strobe.dropShadow) shadowCfg <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              liveCfg <= '0;
    else if (strobe.commit) liveCfg <= shadowCfg;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = (addr == CFG_ADDR) ? {{PAD_W{1'b0}}, liveCfg} : '0;
    end else begin : g_nopad
      assign rdata = (addr == CFG_ADDR) ? liveCfg[DATA_W-1:0] : '0;
    end
  endgenerate

  // Live register only moves on a commit strobe from the tracker
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(liveCfg));

endmodule

// File: rtl/keyedConfigReg.sv
module keyedConfigReg
  import keycfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16,
  parameter logic [ADDR_W-1:0] OPEN_ADDR  = 12'h650,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 12'h654,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR = 12'h658,
  parameter logic [DATA_W-1:0] OPEN_KEY   = 32'h0000_009A,
  parameter logic [DATA_W-1:0] CLOSE_KEY  = 32'h0000_000C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CFG_W-1:0]  cfgOut,
  output logic              seqBusy
);

  cfgStrobe_t strobe;

  keySeqCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OPEN_ADDR(OPEN_ADDR), .CFG_ADDR(CFG_ADDR), .CLOSE_ADDR(CLOSE_ADDR),
    .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .strobe(strobe), .busy(seqBusy)
  );

  keyCfgData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .CFG_ADDR(CFG_ADDR)
  ) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wcfg(wdata[CFG_W-1:0]),
    .addr(addr), .liveCfg(cfgOut), .rdata(rdata)
  );

  // Only a write to the closing address can move the committed value
  assert_no_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != CLOSE_ADDR) |=> $stable(cfgOut));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(cfgOut) && $stable(seqBusy)));

endmodule

// File: tb/test_keyedConfigReg.sv
module test_keyedConfigReg;
  localparam logic [11:0] KO = 12'h650;
  localparam logic [11:0] KC = 12'h654;
  localparam logic [11:0] KX = 12'h658;
  localparam logic [11:0] IDLE_ADDR = 12'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = IDLE_ADDR;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] cfgOut;
  logic        seqBusy;

  int checks = 0;
  int errors = 0;
  int mState = 0;
  logic [15:0] mShadow = '0;
  logic [15:0] mLive = '0;

  always #2.5 clk = ~clk;

  keyedConfigReg i_keyedConfigReg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cfgOut(cfgOut), .seqBusy(seqBusy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == KO) begin
      mShadow = '0;
      mState = (d == 32'h9A) ? 1 : 0;
    end else if (a == KC) begin
      if (mState == 1) begin mShadow = d[15:0]; mState = 2; end
      else begin mShadow = '0; mState = 0; end
    end else if (a == KX) begin
      if (mState == 2 && d == 32'hC) mLive = mShadow;
      else mShadow = '0;
      mState = 0;
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = IDLE_ADDR;
    modelWrite(a, d);
  endtask

  task automatic checkAll(input string req);
    chk(cfgOut == mLive, req, {16'h0, cfgOut}, {16'h0, mLive});
    chk(seqBusy == (mState != 0), req, {31'h0, seqBusy}, {31'h0, mState != 0});
    addr = KC; #0.5;
    chk(rdata == {16'h0, mLive}, {req, " R10 read"}, rdata, {16'h0, mLive});
    addr = IDLE_ADDR;
  endtask

  function automatic logic [11:0] pickAddr(input int r);
    case (r % 8)
      0, 1: return KO;
      2, 3: return KC;
      4, 5: return KX;
      6: return 12'h004;
      default: return 12'h700;
    endcase
  endfunction

  function automatic logic [31:0] pickData(input logic [11:0] a, input int r);
    logic [31:0] raw;
    raw = $urandom;
    if (a == KO && r % 3 != 0) return 32'h9A;
    if (a == KX && r % 3 != 0) return 32'hC;
    if (r % 5 == 0) return raw | 32'h9A;
    return raw;
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R2, R3: full sequence
    busWrite(KO, 32'h9A);       checkAll("R3 armed");
    busWrite(KC, 32'hFFFF_1234); checkAll("R3 loaded");
    busWrite(KX, 32'hC);        checkAll("R2 commit");
    chk(cfgOut == 16'h1234, "R2 value", {16'h0, cfgOut}, 32'h1234);

    // R4: wrong open key, including stray upper bits
    busWrite(KO, 32'h19A);      checkAll("R4 bad open");
    busWrite(KC, 32'h4444);     busWrite(KX, 32'hC); checkAll("R4 no commit");

    // R5: config write while idle
    busWrite(KC, 32'h5151);     checkAll("R5 stray cfg");
    busWrite(KX, 32'hC);        checkAll("R5 no commit");
    chk(cfgOut == 16'h1234, "R5 held", {16'h0, cfgOut}, 32'h1234);

    // R6: bad closing key then good one
    busWrite(KO, 32'h9A); busWrite(KC, 32'h5555); busWrite(KX, 32'hD);
    checkAll("R6 bad close");
    busWrite(KX, 32'hC);        checkAll("R6 shadow gone");

    // R7: out of order
    busWrite(KO, 32'h9A); busWrite(KX, 32'hC); checkAll("R7 close early");
    busWrite(KO, 32'h9A); busWrite(KC, 32'h6666); busWrite(KC, 32'h7777);
    checkAll("R7 double cfg");
    busWrite(KX, 32'hC);        checkAll("R7 no commit");

    // R8: restart
    busWrite(KO, 32'h9A); busWrite(KC, 32'hAAAA); busWrite(KO, 32'h9A);
    checkAll("R8 restart");
    busWrite(KX, 32'hC);        checkAll("R8 shadow dropped");
    busWrite(KO, 32'h9A); busWrite(KC, 32'hAAAA); busWrite(KO, 32'h9A);
    busWrite(KC, 32'hBBBB); busWrite(KX, 32'hC);
    checkAll("R8 second value");
    chk(cfgOut == 16'hBBBB, "R8 value", {16'h0, cfgOut}, 32'hBBBB);

    // R9: unrelated writes inside a sequence
    busWrite(KO, 32'h9A); busWrite(12'h700, 32'h9A);
    busWrite(KC, 32'h7777); busWrite(12'h004, 32'hC);
    checkAll("R9 interleaved");
    busWrite(KX, 32'hC);        checkAll("R9 commit");
    chk(cfgOut == 16'h7777, "R9 value", {16'h0, cfgOut}, 32'h7777);

    // R10: reads of key and unrelated addresses
    addr = KO; #0.5; chk(rdata == 0, "R10 open key read", rdata, 0);
    addr = KX; #0.5; chk(rdata == 0, "R10 close key read", rdata, 0);
    addr = 12'h700; #0.5; chk(rdata == 0, "R10 other read", rdata, 0);
    addr = IDLE_ADDR;

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [11:0] a;
      r = $urandom;
      a = pickAddr(r);
      busWrite(a, pickData(a, $urandom));
      checkAll("R2 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule